// File: doc/BRIEF.md
# Fault latch and reporting unit

This unit sits between the analog protection monitors of a multi-channel class-D power stage and the rest of the control logic. Each cycle it takes live monitor flags: supply over- and undervoltage, charge-pump undervoltage, power-on reset, load dump, overtemperature shutdown and warning, and per-channel overcurrent and DC offset. From these it keeps two sticky fault bytes that software reads, and one live status byte. The live byte carries a small encoded field for the overtemperature warning level.

From the live and sticky state it derives the actions for the output-mode controller. These are a standby request, a request to put every channel in high impedance, a per-channel high-impedance request, and a hard-mute request. It also drives two open-drain indicator pins. The fault pin reports every fault class. The second pin reports a signal chosen by configuration, which can be tweeter detect, clipping or overtemperature warning, and it can also report thermal foldback.

A read of a sticky byte is signalled to the unit by a one-cycle pulse. The read clears the bits of that byte whose condition has gone away.

Top module: `fault_report_unit`

## Requirements
- R1: After reset, both sticky bytes read 0x00.
- R2: The global sticky byte records, one clock after the condition is seen, bit 0 overtemperature warning, bit 1 DC offset on any channel, bit 2 overcurrent on any channel, bit 3 overtemperature shutdown, bit 4 charge-pump undervoltage, bit 5 analog supply undervoltage, bit 6 power supply undervoltage, bit 7 power supply overvoltage.
- R3: The channel sticky byte records overcurrent of channel c in bit c and DC offset of channel c in bit NUM_CH+c, one clock after the condition is seen.
- R4: A sticky bit stays set until a read pulse for its byte arrives. At that edge the bit clears unless its condition is active in the same cycle, in which case it stays set.
- R5: The live byte is combinational from the inputs: bit 0 power overvoltage, bit 1 power undervoltage, bit 2 analog supply undervoltage, bit 3 charge-pump undervoltage, bit 4 overtemperature shutdown. Bits 7:5 are 000 without a warning, and {level[1:0],1} with a warning, giving 001, 011, 101 or 111.
- R6: Power supply over- or undervoltage, analog undervoltage or charge-pump undervoltage, live or sticky, asserts the all-channel high-impedance request and the fault pin.
- R7: Power-on reset and load dump assert the standby request and the fault pin only while they are live, and are never latched. Power-on reset also asserts hard mute.
- R8: Overtemperature shutdown, live or sticky, asserts standby, hard mute and the fault pin.
- R9: Overcurrent or DC offset on channel c, live or sticky, asserts the fault pin and the high-impedance request of channel c only. When the DC-offset-no-shutdown control is set, DC offset still reaches the fault pin and the sticky bytes but no longer requests high impedance.
- R10: The indicator pin source select is 00 for tweeter detect, 01 for clip, 10 for live overtemperature warning, and 11 for no source.
- R11: When foldback reporting is enabled, foldback on any channel also asserts the indicator pin, whatever the source select.
- R12: The fault pin is released when no fault condition is live or sticky. Overtemperature warning alone does not assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on reset monitor |
| ldump_i | input | 1 | Load dump monitor |
| pv_ov_i | input | 1 | Power supply overvoltage |
| pv_uv_i | input | 1 | Power supply undervoltage |
| av_uv_i | input | 1 | Analog supply undervoltage |
| cp_uv_i | input | 1 | Charge-pump undervoltage |
| otsd_i | input | 1 | Overtemperature shutdown |
| otw_i | input | 1 | Overtemperature warning |
| otw_lvl_i | input | 2 | Warning level 0..3 |
| oc_i | input | NUM_CH | Per-channel overcurrent |
| dco_i | input | NUM_CH | Per-channel DC offset |
| clip_i | input | 1 | Clip detect |
| tweet_i | input | 1 | Tweeter detect result |
| fold_i | input | NUM_CH | Per-channel thermal foldback |
| cfg_pin_sel_i | input | 2 | Indicator pin source select |
| cfg_fold_rpt_i | input | 1 | Add foldback to indicator pin |
| cfg_dco_noshut_i | input | 1 | DC offset reports without shutdown |
| rd_glob_i | input | 1 | Read pulse for global sticky byte |
| rd_chan_i | input | 1 | Read pulse for channel sticky byte |
| glob_lat_o | output | 8 | Global sticky fault byte |
| chan_lat_o | output | 2*NUM_CH | Channel sticky fault byte |
| live_o | output | 8 | Live status byte |
| standby_o | output | 1 | Standby request |
| all_hiz_o | output | 1 | All-channel high-impedance request |
| ch_hiz_o | output | NUM_CH | Per-channel high-impedance request |
| hard_mute_o | output | 1 | Mute without ramp |
| fault_pd_o | output | 1 | Pull-down enable of the fault pin (pin low = fault) |
| clipotw_pd_o | output | 1 | Pull-down enable of the indicator pin |

## Verification
A read pulse and a new occurrence of a condition can land on the same clock edge. The sticky byte must then keep the bit rather than drop it. The bench provokes this in a long pseudo-random phase where read pulses and sparse fault events overlap freely. It also provokes it in directed steps where a shutdown condition is still live while its byte is read. After every edge the bench compares both sticky bytes with a model that it updates from the requirements. Between edges it compares the action requests and both pins with values worked out from the live inputs and that model.

// File: rtl/fault_rpt_pkg.sv
package fault_rpt_pkg;

    typedef enum logic [1:0] {
        PIN_TWEET = 2'b00,
        PIN_CLIP  = 2'b01,
        PIN_OTW   = 2'b10,
        PIN_NONE  = 2'b11
    } pin_src_e;

    typedef struct packed {
        logic pv_ov;
        logic pv_uv;
        logic av_uv;
        logic cp_uv;
        logic otsd;
        logic otw;
        logic [1:0] otw_lvl;
    } glob_mon_t;

    function automatic logic [2:0] warn_field(input logic w, input logic [1:0] lvl);
        return w ? {lvl, 1'b1} : 3'b000;
    endfunction

    function automatic logic [7:0] pack_glob_set(input glob_mon_t m,
                                                 input logic any_oc,
                                                 input logic any_dco);
        return {m.pv_ov, m.pv_uv, m.av_uv, m.cp_uv, m.otsd, any_oc, any_dco, m.otw};
    endfunction

    function automatic logic [7:0] pack_live(input glob_mon_t m);
        return {warn_field(m.otw, m.otw_lvl), m.otsd, m.cp_uv, m.av_uv, m.pv_uv, m.pv_ov};
    endfunction

endpackage

// File: rtl/fault_sticky_reg.sv
module fault_sticky_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (clr_i ? '0 : q_o) | set_i;
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    a_r4_clear_idle: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i == '0) |=> (q_o == '0));

    a_r4_no_drop: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

endmodule

// File: rtl/fault_action.sv
module fault_action #(
    parameter int NUM_CH = 4
) (
    input  logic              por_i,
    input  logic              ldump_i,
    input  logic [3:0]        sup_live_i,
    input  logic [3:0]        sup_lat_i,
    input  logic              otsd_live_i,
    input  logic              otsd_lat_i,
    input  logic [NUM_CH-1:0] oc_eff_i,
    input  logic [NUM_CH-1:0] dco_eff_i,
    input  logic              dco_noshut_i,
    output logic              standby_o,
    output logic              all_hiz_o,
    output logic [NUM_CH-1:0] ch_hiz_o,
    output logic              hard_mute_o,
    output logic              fault_pd_o
);

    logic otsd_eff;
    logic sup_eff;

    always_comb begin
        otsd_eff    = otsd_live_i | otsd_lat_i;
        sup_eff     = |(sup_live_i | sup_lat_i);
        standby_o   = por_i | ldump_i | otsd_eff;
        hard_mute_o = por_i | otsd_eff;
        all_hiz_o   = sup_eff;
        fault_pd_o  = por_i | ldump_i | otsd_eff | sup_eff | (|oc_eff_i) | (|dco_eff_i);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_hiz_o[c] = oc_eff_i[c] | (dco_eff_i[c] & ~dco_noshut_i);
    end

endmodule

// File: rtl/indicator_mux.sv
module indicator_mux #(
    parameter int NUM_CH = 4
) (
    input  fault_rpt_pkg::pin_src_e sel_i,
    input  logic                    fold_rpt_i,
    input  logic                    tweet_i,
    input  logic                    clip_i,
    input  logic                    otw_i,
    input  logic [NUM_CH-1:0]       fold_i,
    output logic                    pd_o
);
    import fault_rpt_pkg::*;

    logic src;

    always_comb begin
        unique case (sel_i)
            PIN_TWEET: src = tweet_i;
            PIN_CLIP:  src = clip_i;
            PIN_OTW:   src = otw_i;
            default:   src = 1'b0;
        endcase
        pd_o = src | (fold_rpt_i & (|fold_i));
    end

endmodule

// File: rtl/fault_report_unit.sv
module fault_report_unit
    import fault_rpt_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  por_i,
    input  logic                  ldump_i,
    input  logic                  pv_ov_i,
    input  logic                  pv_uv_i,
    input  logic                  av_uv_i,
    input  logic                  cp_uv_i,
    input  logic                  otsd_i,
    input  logic                  otw_i,
    input  logic [1:0]            otw_lvl_i,
    input  logic [NUM_CH-1:0]     oc_i,
    input  logic [NUM_CH-1:0]     dco_i,
    input  logic                  clip_i,
    input  logic                  tweet_i,
    input  logic [NUM_CH-1:0]     fold_i,
    input  logic [1:0]            cfg_pin_sel_i,
    input  logic                  cfg_fold_rpt_i,
    input  logic                  cfg_dco_noshut_i,
    input  logic                  rd_glob_i,
    input  logic                  rd_chan_i,
    output logic [7:0]            glob_lat_o,
    output logic [2*NUM_CH-1:0]   chan_lat_o,
    output logic [7:0]            live_o,
    output logic                  standby_o,
    output logic                  all_hiz_o,
    output logic [NUM_CH-1:0]     ch_hiz_o,
    output logic                  hard_mute_o,
    output logic                  fault_pd_o,
    output logic                  clipotw_pd_o
);

    localparam int CW = 2 * NUM_CH;

    glob_mon_t         mon;
    logic [7:0]        glob_set;
    logic [CW-1:0]     chan_set;
    logic [NUM_CH-1:0] oc_eff;
    logic [NUM_CH-1:0] dco_eff;
    pin_src_e          pin_sel;

    always_comb begin
        mon.pv_ov   = pv_ov_i;
        mon.pv_uv   = pv_uv_i;
        mon.av_uv   = av_uv_i;
        mon.cp_uv   = cp_uv_i;
        mon.otsd    = otsd_i;
        mon.otw     = otw_i;
        mon.otw_lvl = otw_lvl_i;
        glob_set    = pack_glob_set(mon, |oc_i, |dco_i);
        chan_set    = {dco_i, oc_i};
        live_o      = pack_live(mon);
        oc_eff      = oc_i  | chan_lat_o[NUM_CH-1:0];
        dco_eff     = dco_i | chan_lat_o[CW-1:NUM_CH];
        pin_sel     = pin_src_e'(cfg_pin_sel_i);
    end

    fault_sticky_reg #(.W(8)) u_glob (
        .clk(clk), .rst(rst), .set_i(glob_set), .clr_i(rd_glob_i), .q_o(glob_lat_o)
    );

    fault_sticky_reg #(.W(CW)) u_chan (
        .clk(clk), .rst(rst), .set_i(chan_set), .clr_i(rd_chan_i), .q_o(chan_lat_o)
    );

    fault_action #(.NUM_CH(NUM_CH)) u_act (
        .por_i(por_i),
        .ldump_i(ldump_i),
        .sup_live_i({pv_ov_i, pv_uv_i, av_uv_i, cp_uv_i}),
        .sup_lat_i(glob_lat_o[7:4]),
        .otsd_live_i(otsd_i),
        .otsd_lat_i(glob_lat_o[3]),
        .oc_eff_i(oc_eff),
        .dco_eff_i(dco_eff),
        .dco_noshut_i(cfg_dco_noshut_i),
        .standby_o(standby_o),
        .all_hiz_o(all_hiz_o),
        .ch_hiz_o(ch_hiz_o),
        .hard_mute_o(hard_mute_o),
        .fault_pd_o(fault_pd_o)
    );

    indicator_mux #(.NUM_CH(NUM_CH)) u_pin (
        .sel_i(pin_sel),
        .fold_rpt_i(cfg_fold_rpt_i),
        .tweet_i(tweet_i),
        .clip_i(clip_i),
        .otw_i(otw_i),
        .fold_i(fold_i),
        .pd_o(clipotw_pd_o)
    );

    a_r8_otsd_holds_standby: assert property (@(posedge clk) disable iff (rst)
        otsd_i |=> (standby_o && hard_mute_o && fault_pd_o));

    a_r6_uv_holds_hiz: assert property (@(posedge clk) disable iff (rst)
        (pv_uv_i || cp_uv_i) |=> all_hiz_o);

    a_r9_hiz_needs_fault: assert property (@(posedge clk) disable iff (rst)
        (ch_hiz_o != '0 || all_hiz_o) |-> fault_pd_o);

    a_r9_noshut_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_dco_noshut_i && oc_i == '0 && chan_lat_o[NUM_CH-1:0] == '0) |-> (ch_hiz_o == '0));

    a_r11_pin_idle: assert property (@(posedge clk) disable iff (rst)
        (cfg_pin_sel_i == 2'b11 && !cfg_fold_rpt_i) |-> !clipotw_pd_o);

endmodule

// File: tb/fault_report_unit_tb_top.sv
module fault_report_unit_tb_top;

    localparam int CLK_P = 10;
    localparam int NCH   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por, ldump, pv_ov, pv_uv, av_uv, cp_uv, otsd, otw, clip, tweet;
    logic [1:0] lvl, psel;
    logic [NCH-1:0] oc, dco, fold;
    logic frpt, noshut, rdg, rdc;
    logic [7:0] glat, live;
    logic [2*NCH-1:0] clat;
    logic stby, ahiz, hmute, fpd, cpd;
    logic [NCH-1:0] chiz;

    int total = 0;
    int bad   = 0;
    logic [7:0] m0;
    logic [2*NCH-1:0] m1;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #(CLK_P/2) clk = ~clk;

    fault_report_unit #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .por_i(por), .ldump_i(ldump), .pv_ov_i(pv_ov),
        .pv_uv_i(pv_uv), .av_uv_i(av_uv), .cp_uv_i(cp_uv), .otsd_i(otsd),
        .otw_i(otw), .otw_lvl_i(lvl), .oc_i(oc), .dco_i(dco), .clip_i(clip),
        .tweet_i(tweet), .fold_i(fold), .cfg_pin_sel_i(psel),
        .cfg_fold_rpt_i(frpt), .cfg_dco_noshut_i(noshut), .rd_glob_i(rdg),
        .rd_chan_i(rdc), .glob_lat_o(glat), .chan_lat_o(clat), .live_o(live),
        .standby_o(stby), .all_hiz_o(ahiz), .ch_hiz_o(chiz), .hard_mute_o(hmute),
        .fault_pd_o(fpd), .clipotw_pd_o(cpd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic quiet();
        {por, ldump, pv_ov, pv_uv, av_uv, cp_uv, otsd, otw, clip, tweet} = '0;
        lvl = '0; oc = '0; dco = '0; fold = '0;
        rdg = 1'b0; rdc = 1'b0;
    endtask

    // Compares combinational outputs, crosses one edge, then compares sticky bytes.
    task automatic step();
        logic [7:0] s0, exp_live;
        logic [2*NCH-1:0] s1;
        logic [NCH-1:0] oce, dce, exp_hiz;
        logic sup, ot, src;
        #1;
        oce = oc | m1[NCH-1:0];
        dce = dco | m1[2*NCH-1:NCH];
        sup = pv_ov | pv_uv | av_uv | cp_uv | (|m0[7:4]);
        ot  = otsd | m0[3];
        exp_live = {(otw ? {lvl, 1'b1} : 3'b000), otsd, cp_uv, av_uv, pv_uv, pv_ov};
        chk("R5 live byte", live, exp_live);
        chk("R6 all hiz", ahiz, sup);
        chk("R7/R8 standby", stby, por | ldump | ot);
        chk("R7/R8 hard mute", hmute, por | ot);
        for (int c = 0; c < NCH; c++) exp_hiz[c] = oce[c] | (dce[c] & ~noshut);
        chk("R9 channel hiz", chiz, exp_hiz);
        chk("R12 fault pin", fpd, por | ldump | sup | ot | (|oce) | (|dce));
        case (psel)
            2'b00: src = tweet;
            2'b01: src = clip;
            2'b10: src = otw;
            default: src = 1'b0;
        endcase
        chk("R10/R11 indicator pin", cpd, src | (frpt & (|fold)));
        s0 = '0;
        s0[0] = otw; s0[1] = |dco; s0[2] = |oc; s0[3] = otsd;
        s0[4] = cp_uv; s0[5] = av_uv; s0[6] = pv_uv; s0[7] = pv_ov;
        s1 = {dco, oc};
        @(posedge clk);
        m0 = (rdg ? 8'h00 : m0) | s0;
        m1 = (rdc ? '0 : m1) | s1;
        @(negedge clk);
        chk("R2/R4 global sticky", glat, m0);
        chk("R3/R4 channel sticky", clat, m1);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        quiet();
        psel = 2'b11; frpt = 1'b0; noshut = 1'b0;
        m0 = '0; m1 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset global", glat, 8'h00);
        chk("R1 reset channel", clat, '0);

        // R10 R11: exhaustive indicator sweep with no faults
        for (int i = 0; i < 128; i++) begin
            quiet();
            psel = i[1:0]; frpt = i[2]; tweet = i[3]; clip = i[4]; otw = i[5];
            fold = i[6] ? 4'b0100 : 4'b0000;
            step();
        end
        quiet(); rdg = 1'b1; step(); quiet(); step();
        chk("R12 warning-only leaves fault pin idle", fpd, 1'b0);

        // R5: warning level field sweep
        for (int i = 0; i < 8; i++) begin
            quiet(); otw = i[2]; lvl = i[1:0]; step();
        end

        // R7: self-clearing sources
        quiet(); por = 1'b1; step();
        quiet(); step();
        chk("R7 por not latched", stby, 1'b0);
        quiet(); ldump = 1'b1; step();
        quiet(); step();
        chk("R7 load dump not latched", fpd, 1'b0);

        // R8 R4: shutdown held by sticky byte; read while live keeps it
        quiet(); otsd = 1'b1; step();
        quiet(); otsd = 1'b1; rdg = 1'b1; step();
        quiet(); step();
        chk("R8 shutdown remains after condition ends", stby, 1'b1);
        quiet(); rdg = 1'b1; step();
        quiet(); step();
        chk("R4 cleared after idle read", glat, 8'h00);

        // R9: per channel faults, with and without no-shutdown control
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 4; k++) begin
                quiet(); noshut = k[1];
                if (k[0]) dco[c] = 1'b1; else oc[c] = 1'b1;
                step();
                quiet(); rdc = 1'b1; rdg = 1'b1; step();
            end
        end
        quiet(); step();
        noshut = 1'b0;

        // Overlapping events, reads and configurations
        for (int n = 0; n < 600; n++) begin
            lfsr = nxt(lfsr); lfsr = nxt(lfsr); lfsr = nxt(lfsr);
            quiet();
            por   = lfsr[0] & lfsr[1] & lfsr[2];
            ldump = lfsr[3] & lfsr[4] & lfsr[5];
            pv_ov = lfsr[6] & lfsr[7] & lfsr[8];
            pv_uv = lfsr[9] & lfsr[10] & lfsr[11];
            av_uv = lfsr[12] & lfsr[13] & lfsr[14];
            cp_uv = lfsr[15] & lfsr[16] & lfsr[17];
            otsd  = lfsr[18] & lfsr[19] & lfsr[20];
            otw   = lfsr[21]; lvl = lfsr[23:22];
            clip  = lfsr[24]; tweet = lfsr[25];
            rdg   = lfsr[26] & lfsr[27];
            rdc   = lfsr[28] & lfsr[29];
            lfsr = nxt(lfsr); lfsr = nxt(lfsr); lfsr = nxt(lfsr);
            oc   = lfsr[3:0] & lfsr[7:4] & lfsr[11:8];
            dco  = lfsr[15:12] & lfsr[19:16] & lfsr[23:20];
            fold = lfsr[27:24] & lfsr[31:28];
            psel = lfsr[1:0] ^ lfsr[9:8];
            frpt = lfsr[30];
            noshut = lfsr[13] & lfsr[29];
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule